// File: doc/BRIEF.md
# Vectored Interrupt Controller with Level/Edge Capture

This block gathers up to 32 interrupt request lines from peripherals into one interrupt line for a processor. The polarity of each line is fixed at build time: some lines are level-sensitive and others catch a rising edge. Requests are latched in a status word and masked by an enable word. The masked result forms the pending word. A priority encoder turns the pending word into a vector that names the lowest-numbered active source.

Software uses a plain synchronous port of eight 32-bit word registers, selected by byte address. It enables and disables sources with separate set and clear words, so no read-modify-write is needed. It acknowledges sources by writing ones. A two-bit master control word gates the output line and turns hardware capture on or off. While capture is off, software may write the status word directly, which lets it inject test interrupts.

Top module: `irqc_top`

## Requirements
- R1: After reset the status, enable and master words read 0, the vector reads all ones and `irq_o` is low.
- R2: Bits [4:2] of `bus_addr_i` select the word, and the low two bits are ignored. The word map is: 0 status, 1 pending, 2 enable, 3 acknowledge, 4 set-enable, 5 clear-enable, 6 vector, 7 master. Words 3, 4 and 5 are write-only and read 0. Writes to words 1 and 6 have no effect.
- R3: A write to word 3 clears each status bit whose written bit is 1 and leaves the other status bits unchanged.
- R4: A write to word 4 ORs the written value into the enable word.
- R5: A write to word 5 clears each enable bit whose written bit is 1.
- R6: A write to word 7 stores only written bits [1:0]. Master bit 0 gates the output and master bit 1 enables hardware capture.
- R7: A write to word 0 replaces the status word while master bit 1 is 0. It is ignored while master bit 1 is 1.
- R8: With master bit 1 set, a level-sensitive source (`EDGE_SEL` bit 0) that is high sets its status bit on every cycle it stays high.
- R9: With master bit 1 set, a rising edge on an edge-sensitive source (`EDGE_SEL` bit 1) sets its status bit, and the bit stays set until it is acknowledged. With master bit 1 clear, no source changes the status word.
- R10: The pending word (word 1) always equals status AND enable.
- R11: The vector (word 6) reads the index of the lowest set pending bit, or 0xFFFFFFFF when no bit is pending.
- R12: `irq_o` is high exactly when master bit 0 is 1 and the pending word is nonzero.
- R13: When an acknowledge write and a hardware capture hit the same bit in one cycle, the bit ends set.
- R14: Each input passes through two synchronising flops. A source driven between clock edges shows in the status word after the third rising edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_src_i | input | N_SRC | Asynchronous interrupt request lines |
| bus_wr_i | input | 1 | Write strobe for the register port |
| bus_addr_i | input | ADDR_W | Byte address of the register word |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data of the addressed word (combinational) |
| irq_o | output | 1 | Interrupt line to the processor |

## Verification
The in-line assertions check on every cycle that the register updates behave as required. An acknowledge write clears its bits, a status write made while capture is on clears nothing, and status bits fall only on an acknowledge or a direct write. Set-enable and clear-enable writes land as written, a master write keeps only its low two bits, a capture wins over a same-cycle acknowledge, and the vector always points at the lowest pending bit. Only the bench scenarios can show the exact latency of the synchroniser, the difference between level and edge sources held high across an acknowledge, and the read values of the write-only words. A long random run compares every read and the interrupt line against a cycle model built from the requirements.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  // Word offsets; software depends on this order.
  typedef enum logic [2:0] {
    WRD_STATUS  = 3'd0,
    WRD_PEND    = 3'd1,
    WRD_ENABLE  = 3'd2,
    WRD_ACK     = 3'd3,
    WRD_SETEN   = 3'd4,
    WRD_CLREN   = 3'd5,
    WRD_VECTOR  = 3'd6,
    WRD_MASTER  = 3'd7
  } irqc_word_e;

  localparam int unsigned MST_W       = 2;
  localparam int unsigned MST_OUT_BIT = 0;
  localparam int unsigned MST_CAP_BIT = 1;

  // Bits of a after clearing every position set in b.
  function automatic logic [31:0] clear_ones(input logic [31:0] a, input logic [31:0] b);
    return a & ~b;
  endfunction

endpackage

// File: rtl/irqc_sync_edge.sv
module irqc_sync_edge #(
  parameter int unsigned N_SRC    = 32,
  parameter logic [N_SRC-1:0] EDGE_SEL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_i,
  output logic [N_SRC-1:0] hit_o
);

  logic [N_SRC-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= src_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    if (EDGE_SEL[i]) begin : g_edge
      assign hit_o[i] = sync_q[i] & ~prev_q[i];
      // R9
      edge_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o[i] |=> !hit_o[i]);
    end else begin : g_level
      assign hit_o[i] = sync_q[i];
    end
  end

endmodule

// File: rtl/irqc_prio_enc.sv
module irqc_prio_enc #(
  parameter int unsigned N     = 32,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     vec_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);

  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        idx_o = IDX_W'(i);
        any_o = 1'b1;
      end
    end
  end

endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5,
  parameter logic [N_SRC-1:0] EDGE_SEL = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  irq_src_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  import irqc_pkg::*;

  localparam int unsigned OFS_W = ADDR_W - 2;
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [N_SRC-1:0] status_q, status_d, enable_q, enable_d;
  logic [MST_W-1:0] master_q, master_d;
  logic [N_SRC-1:0] wdata_n, raw_hits, cap_gated, pending;
  logic [IDX_W-1:0] vec_idx;
  logic             vec_any;
  irqc_word_e       word;
  logic             unused_addr_lsb;

  // Named events for the checks below.
  logic wr_status, wr_enable, wr_ack, wr_seten, wr_clren, wr_master, cap_on;

  assign unused_addr_lsb = ^bus_addr_i[1:0];
  assign word      = irqc_word_e'(bus_addr_i[ADDR_W-1 -: OFS_W]);
  assign wdata_n   = bus_wdata_i[N_SRC-1:0];
  assign wr_status = bus_wr_i && (word == WRD_STATUS);
  assign wr_enable = bus_wr_i && (word == WRD_ENABLE);
  assign wr_ack    = bus_wr_i && (word == WRD_ACK);
  assign wr_seten  = bus_wr_i && (word == WRD_SETEN);
  assign wr_clren  = bus_wr_i && (word == WRD_CLREN);
  assign wr_master = bus_wr_i && (word == WRD_MASTER);
  assign cap_on    = master_q[MST_CAP_BIT];

  irqc_sync_edge #(.N_SRC(N_SRC), .EDGE_SEL(EDGE_SEL)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .src_i (irq_src_i),
    .hit_o (raw_hits)
  );

  assign cap_gated = cap_on ? raw_hits : '0;

  always_comb begin
    status_d = status_q;
    if (wr_status && !cap_on) status_d = wdata_n;
    if (wr_ack)               status_d = N_SRC'(clear_ones(32'(status_q), 32'(wdata_n)));
    status_d = status_d | cap_gated;   // capture wins over acknowledge
  end

  always_comb begin
    enable_d = enable_q;
    if (wr_enable) enable_d = wdata_n;
    if (wr_seten)  enable_d = enable_q | wdata_n;
    if (wr_clren)  enable_d = N_SRC'(clear_ones(32'(enable_q), 32'(wdata_n)));
  end

  assign master_d = wr_master ? bus_wdata_i[MST_W-1:0] : master_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
      master_q <= '0;
    end else begin
      status_q <= status_d;
      enable_q <= enable_d;
      master_q <= master_d;
    end
  end

  assign pending = status_q & enable_q;

  irqc_prio_enc #(.N(N_SRC)) u_prio (
    .vec_i (pending),
    .idx_o (vec_idx),
    .any_o (vec_any)
  );

  assign irq_o = master_q[MST_OUT_BIT] & vec_any;

  always_comb begin
    unique case (word)
      WRD_STATUS: bus_rdata_o = DATA_W'(status_q);
      WRD_PEND:   bus_rdata_o = DATA_W'(pending);
      WRD_ENABLE: bus_rdata_o = DATA_W'(enable_q);
      WRD_VECTOR: bus_rdata_o = vec_any ? DATA_W'(vec_idx) : '1;
      WRD_MASTER: bus_rdata_o = DATA_W'(master_q);
      default:    bus_rdata_o = '0;
    endcase
  end

  // R3
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ack && !cap_on) |=> ((status_q & $past(wdata_n)) == '0));
  // R7
  status_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_status && cap_on) |=> ((status_q & $past(status_q)) == $past(status_q)));
  // R9
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ack && !wr_status) |=> (($past(status_q) & ~status_q) == '0));
  // R4
  seten_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_seten |=> ((enable_q & $past(wdata_n)) == $past(wdata_n)));
  // R5
  clren_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clren |=> ((enable_q & $past(wdata_n)) == '0));
  // R6
  master_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_master |=> (master_q == $past(bus_wdata_i[MST_W-1:0])));
  // R13
  cap_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ack && (cap_gated != '0)) |=> ((status_q & $past(cap_gated)) == $past(cap_gated)));
  // R11
  vec_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_any |-> (pending[vec_idx] && ((pending & ~({N_SRC{1'b1}} << vec_idx)) == '0)));
  // R12
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (master_q[MST_OUT_BIT] && ((status_q & enable_q) != '0)));

endmodule

// File: tb/irqc_top_tb.sv
module irqc_top_tb;

  localparam logic [31:0] EDGE = 32'hFFFF_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        wr = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_ff1 = '0, m_ff2 = '0, m_prev = '0, m_st = '0, m_en = '0;
  logic [1:0]  m_mst = '0;

  always #5 clk = ~clk;

  irqc_top #(.N_SRC(32), .DATA_W(32), .ADDR_W(5), .EDGE_SEL(EDGE)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_src_i(src), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [31:0] exp_vector(input logic [31:0] p);
    for (int i = 0; i < 32; i++) if (p[i]) return 32'(i);
    return 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] exp_read(input logic [2:0] ofs);
    case (ofs)
      3'd0: return m_st;
      3'd1: return m_st & m_en;
      3'd2: return m_en;
      3'd6: return exp_vector(m_st & m_en);
      3'd7: return {30'd0, m_mst};
      default: return '0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_tick();
    logic [31:0] cap, nst;
    logic [2:0]  ofs;
    ofs = addr[4:2];
    cap = m_mst[1] ? ((m_ff2 & ~EDGE) | (m_ff2 & ~m_prev & EDGE)) : '0;
    nst = m_st;
    if (wr) begin
      case (ofs)
        3'd0: if (!m_mst[1]) nst = wdata;
        3'd2: m_en = wdata;
        3'd3: nst = m_st & ~wdata;
        3'd4: m_en = m_en | wdata;
        3'd5: m_en = m_en & ~wdata;
        3'd7: m_mst = wdata[1:0];
        default: ;
      endcase
    end
    m_st   = nst | cap;
    m_prev = m_ff2;
    m_ff2  = m_ff1;
    m_ff1  = src;
  endtask

  task automatic step();
    @(posedge clk);
    model_tick();
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic do_wr(input logic [2:0] ofs, input logic [31:0] val);
    wr = 1'b1; addr = {ofs, 2'b00}; wdata = val;
    step();
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] ofs, input logic [31:0] exp);
    wr = 1'b0; addr = {ofs, 2'b01};  // low bits must be ignored (R2)
    #1;
    check(tag, rdata, exp);
  endtask

  task automatic irq_chk(input string tag, input logic exp);
    #1;
    check(tag, {31'd0, irq}, {31'd0, exp});
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_chk("R1 status", 3'd0, 32'h0);
    rd_chk("R1 enable", 3'd2, 32'h0);
    rd_chk("R1 master", 3'd7, 32'h0);
    rd_chk("R1 vector", 3'd6, 32'hFFFF_FFFF);
    irq_chk("R1 irq", 1'b0);
    // R2 write-only words read zero
    do_wr(3'd4, 32'h0000_0300);
    rd_chk("R2 seten reads 0", 3'd4, 32'h0);
    rd_chk("R2 ack reads 0", 3'd3, 32'h0);
    rd_chk("R2 clren reads 0", 3'd5, 32'h0);
    do_wr(3'd5, 32'h0000_0300);
    do_wr(3'd1, 32'hFFFF_FFFF);
    rd_chk("R2 pending write ignored", 3'd1, 32'h0);
    // R7 direct status write while capture off
    do_wr(3'd0, 32'h0000_8421);
    rd_chk("R7 status write", 3'd0, 32'h0000_8421);
    do_wr(3'd2, 32'h0000_0401);
    rd_chk("R10 pending", 3'd1, 32'h0000_0401);
    rd_chk("R11 vector low", 3'd6, 32'd0);
    irq_chk("R12 gated off", 1'b0);
    do_wr(3'd7, 32'hFFFF_FFFD);
    rd_chk("R6 master low bits", 3'd7, 32'h1);
    irq_chk("R12 on", 1'b1);
    do_wr(3'd3, 32'h0000_0001);
    rd_chk("R3 ack", 3'd0, 32'h0000_8420);
    rd_chk("R11 vector 10", 3'd6, 32'd10);
    do_wr(3'd4, 32'h0000_0020);
    rd_chk("R4 seten", 3'd2, 32'h0000_0421);
    rd_chk("R11 vector 5", 3'd6, 32'd5);
    do_wr(3'd5, 32'h0000_0420);
    rd_chk("R5 clren", 3'd2, 32'h0000_0001);
    rd_chk("R11 none pending", 3'd6, 32'hFFFF_FFFF);
    irq_chk("R12 nothing pending", 1'b0);
    // R7 locked while capture on
    do_wr(3'd7, 32'h3);
    do_wr(3'd0, 32'h0000_FFFF);
    rd_chk("R7 status locked", 3'd0, 32'h0000_8420);
    do_wr(3'd3, 32'hFFFF_FFFF);
    // R14 latency and R8 level capture
    src[3] = 1'b1;
    step(); step();
    rd_chk("R14 not yet after two edges", 3'd0, 32'h0);
    step();
    rd_chk("R14 set after third edge", 3'd0, 32'h0000_0008);
    do_wr(3'd3, 32'h0000_0008);
    rd_chk("R8 level held re-sets", 3'd0, 32'h0000_0008);
    src[3] = 1'b0;
    step(); step(); step();
    do_wr(3'd3, 32'h0000_0008);
    rd_chk("R8 cleared after drop", 3'd0, 32'h0);
    // R9 edge capture sticks
    src[20] = 1'b1; step(); src[20] = 1'b0;
    repeat (6) step();
    rd_chk("R9 edge sticky", 3'd0, 32'h0010_0000);
    do_wr(3'd3, 32'h0010_0000);
    rd_chk("R9 edge acked", 3'd0, 32'h0);
    // R9 no capture while capture off
    do_wr(3'd7, 32'h1);
    src[21] = 1'b1; step(); src[21] = 1'b0;
    repeat (5) step();
    rd_chk("R9 capture disabled", 3'd0, 32'h0);
    do_wr(3'd7, 32'h3);
    // R13 capture vs ack in the same cycle
    src[22] = 1'b1;
    step(); step();
    do_wr(3'd3, 32'h0040_0000);
    rd_chk("R13 capture wins", 3'd0, 32'h0040_0000);
    src[22] = 1'b0;
    step();
    do_wr(3'd3, 32'hFFFF_FFFF);
    rd_chk("R13 later ack clears", 3'd0, 32'h0);

    // Random phase against the cycle model
    void'($urandom(32'd20240611));
    for (int n = 0; n < 4000; n++) begin
      logic [2:0] ofs;
      for (int b = 0; b < 32; b++)
        if ($urandom_range(0, 15) == 0) src[b] = ~src[b];
      ofs = 3'($urandom_range(0, 7));
      rd_chk("R2 R10 R11 random read", ofs, exp_read(ofs));
      irq_chk("R12 random irq", m_mst[0] && ((m_st & m_en) != 0));
      if ($urandom_range(0, 2) != 0) begin
        wr = 1'b1;
        addr = {3'($urandom_range(0, 7)), 2'($urandom_range(0, 3))};
        wdata = ($urandom_range(0, 1) != 0) ? $urandom() : (32'h1 << $urandom_range(0, 31));
      end
      step();
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule